// File: doc/BRIEF.md
# Asynchronous Serial Frame Engine

This block converts bytes into asynchronous serial frames and back. It contains a transmitter and a receiver, both timed by a one-cycle `baud_tick` pulse from an external rate divider, with `OVS` ticks (16 by default) per bit. The character length is 5 to 8 bits. An optional parity bit can follow the data. Parity is odd or even, and it is computed over either the ones or the zeros of the character. The transmitter sends one or two stop bits. Optional flow control holds back new transmit frames while the peer's clear-to-send line is high, and drives a request-to-send line from the receive buffer's free-space signal. When flow control is off, each change of the clear-to-send line produces an event pulse.

The transmitter state machine is `TX_IDLE → TX_START → TX_DATA → (TX_PAR) → TX_STOP → TX_IDLE`:
- It leaves `TX_IDLE` when a byte is accepted (`tx_valid && tx_ready`).
- Each later state advances at the last tick of a bit.
- `TX_DATA` goes to `TX_PAR` only when parity is on.
- `TX_STOP` returns to idle after one or two stop bits.

The receiver state machine is `RX_IDLE → RX_START → RX_DATA → (RX_PAR) → RX_STOP → RX_IDLE`:
- It leaves `RX_IDLE` on a synchronized low level.
- `RX_START` falls back to `RX_IDLE` if the line is high again at the middle of the start bit.
- `RX_STOP` delivers the byte at the middle of the stop bit. It goes to `RX_IDLE`, or to `RX_HOLD` when the stop bit is low.
- `RX_HOLD` waits for the line to return high before going to `RX_IDLE`.

Top module: `uart_frame_core`

## Requirements
- R1: A transmit frame is one low start bit, then the character LSB first, then the optional parity bit, then the high stop bits, with each bit lasting `OVS` ticks. The `cfg_char_size` encoding is 0 = 5 bits, 1 = 6, 2 = 7 and 3 = 8.
- R2: The parity bit counts ones when `cfg_par_zeros`=0 and zeros when it is 1, over the character bits plus the parity bit. The count is made odd when `cfg_par_odd`=1 and even when it is 0.
- R3: `cfg_stop2`=0 sends one stop bit and 1 sends two. `tx_busy` stays high for the whole frame, stop bits included.
- R4: The receiver samples each bit at tick `OVS/2` of that bit. It delivers the character right-aligned with the upper bits zero, and pulses `rx_valid` for exactly one cycle per frame.
- R5: A low stop bit pulses `frame_err` in the same cycle as `rx_valid`. The receiver then waits for the line to go high before it looks for a new start bit.
- R6: A start bit that is high again at its midpoint is dropped, and no byte is produced.
- R7: With `cfg_dpfe_en`=1, a data or parity bit whose samples at ticks `OVS/4` and `3*OVS/4` differ raises `frame_err` for that byte. With `cfg_dpfe_en`=0 such a bit raises no error.
- R8: With `cfg_hfc_en`=1 and `cfg_cts_dis`=0, no new frame starts while the synchronized `cts_n` is high. With `cfg_cts_dis`=1, `cts_n` is ignored.
- R9: `cts_change` pulses once for each change of the synchronized `cts_n`, only while `cfg_hfc_en`=0 and `cfg_cts_dis`=0.
- R10: `rts_n` equals the inverse of `rx_space` when `cfg_hfc_en`=1, and is 0 otherwise.
- R11: After reset, `txd` is 1, `tx_busy`, `rx_busy` and `rx_valid` are 0, and `rx_busy` is high while a frame is being received.
- R12: A parity mismatch sets `rx_par_err`, which is held with the byte, and pulses `par_err` in the same cycle as `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle oversampling tick |
| cfg_char_size | input | 2 | Character length code (0..3 → 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd count, 0 = even count |
| cfg_par_zeros | input | 1 | 1 = count zeros, 0 = count ones |
| cfg_stop2 | input | 1 | 1 = two stop bits on transmit |
| cfg_hfc_en | input | 1 | Flow control enable |
| cfg_cts_dis | input | 1 | Ignore the clear-to-send input |
| cfg_dpfe_en | input | 1 | Data/parity bit stability check enable |
| tx_valid | input | 1 | Byte offered for transmission |
| tx_data | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Transmitter accepts the byte this cycle |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_valid | output | 1 | Received byte pulse |
| rx_data | output | 8 | Received character |
| rx_par_err | output | 1 | Parity error of the held byte |
| frame_err | output | 1 | Frame error pulse |
| par_err | output | 1 | Parity error pulse |
| cts_n | input | 1 | Peer clear-to-send, active low |
| rts_n | output | 1 | Request-to-send, active low |
| rx_space | input | 1 | Receive buffer can take a byte |
| cts_change | output | 1 | Clear-to-send change event |
| tx_busy | output | 1 | Transmit frame in progress |
| rx_busy | output | 1 | Receive frame in progress |

## Verification
The frame-error pulse and the parity-error pulse come from separate checks, yet both are registered at the middle of the same stop bit, so they can fall in the same cycle as `rx_valid`. The bench provokes this with a frame that has both a wrong parity bit and a low stop bit. Its scoreboard entry expects `rx_valid`, `frame_err`, `par_err` and `rx_par_err` all high in a single cycle. The entry also expects no stray pulse on either error line in the cycles around it.

// File: rtl/ufe_pkg.sv
package ufe_pkg;

    typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_state_e;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD} rx_state_e;

    // index of the last data bit for a size code (5..8 bits -> 4..7)
    function automatic logic [2:0] last_bit_idx(input logic [1:0] sz);
        return 3'd4 + {1'b0, sz};
    endfunction

    function automatic logic [7:0] char_mask(input logic [1:0] sz);
        return 8'hFF >> (2'd3 - sz);
    endfunction

    // parity bit over the character; the zero count differs from the one count when the length is odd
    function automatic logic par_bit(input logic [7:0] d, input logic [1:0] sz,
                                     input logic odd, input logic zeros);
        logic ones;
        ones = ^(d & char_mask(sz));
        return ones ^ (zeros & ~sz[0]) ^ odd ^ zeros;
    endfunction

endpackage

// File: rtl/ufe_tx.sv
module ufe_tx import ufe_pkg::*; #(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       go,
    input  logic [7:0] din,
    input  logic [1:0] csize,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       par_zeros,
    input  logic       stop2,
    output logic       txd,
    output logic       busy
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] LAST_T = CW'(OVS - 1);

    tx_state_e      st, nx;
    logic [CW-1:0]  cnt;
    logic [2:0]     idx;
    logic [7:0]     sh;
    logic           pbit;
    logic           bit_end, last_dat;

    assign bit_end  = tick && (cnt == LAST_T);
    assign last_dat = (idx == last_bit_idx(csize));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= nx;
    end

    always_comb begin
        nx = st;
        unique case (st)
            TX_IDLE:  if (go) nx = TX_START;
            TX_START: if (bit_end) nx = TX_DATA;
            TX_DATA:  if (bit_end && last_dat) nx = par_en ? TX_PAR : TX_STOP;
            TX_PAR:   if (bit_end) nx = TX_STOP;
            TX_STOP:  if (bit_end && idx == {2'b00, stop2}) nx = TX_IDLE;
            default:  nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            idx  <= '0;
            sh   <= '0;
            pbit <= 1'b0;
        end else if (st == TX_IDLE) begin
            cnt <= '0;
            idx <= '0;
            if (go) begin
                sh   <= din;
                pbit <= par_bit(din, csize, par_odd, par_zeros);
            end
        end else if (tick) begin
            cnt <= (cnt == LAST_T) ? '0 : cnt + 1'b1;
            if (bit_end) begin
                if (st == TX_DATA) begin
                    sh  <= sh >> 1;
                    idx <= last_dat ? 3'd0 : idx + 3'd1;
                end else if (st == TX_STOP) begin
                    idx <= idx + 3'd1;
                end
            end
        end
    end

    always_comb begin
        busy = (st != TX_IDLE);
        unique case (st)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh[0];
            TX_PAR:   txd = pbit;
            default:  txd = 1'b1;
        endcase
    end

    p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_IDLE && go) |=> (!txd && busy));
    p_stop_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(txd));

endmodule

// File: rtl/ufe_rx.sv
module ufe_rx import ufe_pkg::*; #(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_s,
    input  logic [1:0] csize,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       par_zeros,
    input  logic       dpfe_en,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_par_err,
    output logic       frame_err,
    output logic       par_err,
    output logic       busy
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] Q1     = CW'(OVS / 4 - 1);
    localparam logic [CW-1:0] MID    = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] Q3     = CW'(3 * OVS / 4 - 1);
    localparam logic [CW-1:0] LAST_T = CW'(OVS - 1);

    rx_state_e      st, nx;
    logic [CW-1:0]  cnt;
    logic [2:0]     idx;
    logic [7:0]     sh, aligned;
    logic           pbit, q1s, facc, perr_now;
    logic           mid_hit, end_hit, last_dat;

    assign mid_hit  = tick && (cnt == MID);
    assign end_hit  = tick && (cnt == LAST_T);
    assign last_dat = (idx == last_bit_idx(csize));
    assign aligned  = sh >> (2'd3 - csize);
    assign perr_now = par_en && (pbit != par_bit(aligned, csize, par_odd, par_zeros));
    assign busy     = (st != RX_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= nx;
    end

    always_comb begin
        nx = st;
        unique case (st)
            RX_IDLE:  if (!rx_s) nx = RX_START;
            RX_START: if (mid_hit && rx_s) nx = RX_IDLE;
                      else if (end_hit) nx = RX_DATA;
            RX_DATA:  if (end_hit && last_dat) nx = par_en ? RX_PAR : RX_STOP;
            RX_PAR:   if (end_hit) nx = RX_STOP;
            RX_STOP:  if (mid_hit) nx = rx_s ? RX_IDLE : RX_HOLD;
            RX_HOLD:  if (rx_s) nx = RX_IDLE;
            default:  nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            idx  <= '0;
            sh   <= '0;
            pbit <= 1'b0;
            q1s  <= 1'b0;
            facc <= 1'b0;
        end else if (st == RX_IDLE) begin
            cnt  <= '0;
            idx  <= '0;
            facc <= 1'b0;
        end else if (tick) begin
            cnt <= (cnt == LAST_T) ? '0 : cnt + 1'b1;
            if (st == RX_DATA || st == RX_PAR) begin
                if (cnt == Q1) q1s <= rx_s;
                if (cnt == Q3 && dpfe_en && rx_s != q1s) facc <= 1'b1;
                if (cnt == MID) begin
                    if (st == RX_DATA) sh <= {rx_s, sh[7:1]};
                    else               pbit <= rx_s;
                end
            end
            if (end_hit && st == RX_DATA) idx <= last_dat ? 3'd0 : idx + 3'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid   <= 1'b0;
            rx_data    <= '0;
            rx_par_err <= 1'b0;
            frame_err  <= 1'b0;
            par_err    <= 1'b0;
        end else begin
            rx_valid  <= 1'b0;
            frame_err <= 1'b0;
            par_err   <= 1'b0;
            if (st == RX_STOP && mid_hit) begin
                rx_valid   <= 1'b1;
                rx_data    <= aligned;
                rx_par_err <= perr_now;
                frame_err  <= facc | ~rx_s;
                par_err    <= perr_now;
            end
        end
    end

    p_glitch_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_START && mid_hit && rx_s) |=> (st == RX_IDLE && !rx_valid));
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    p_perr_with_byte_r12: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> (rx_valid && rx_par_err));
    p_low_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_STOP && mid_hit && !rx_s) |=> (frame_err && rx_valid));

endmodule

// File: rtl/uart_frame_core.sv
module uart_frame_core import ufe_pkg::*; #(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic [1:0] cfg_char_size,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_par_zeros,
    input  logic       cfg_stop2,
    input  logic       cfg_hfc_en,
    input  logic       cfg_cts_dis,
    input  logic       cfg_dpfe_en,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    output logic       txd,
    input  logic       rxd,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_par_err,
    output logic       frame_err,
    output logic       par_err,
    input  logic       cts_n,
    output logic       rts_n,
    input  logic       rx_space,
    output logic       cts_change,
    output logic       tx_busy,
    output logic       rx_busy
);
    logic [1:0] rx_sync, cts_sync;
    logic       cts_prev, cts_block, tx_go;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sync    <= 2'b11;
            cts_sync   <= 2'b11;
            cts_prev   <= 1'b1;
            cts_change <= 1'b0;
        end else begin
            rx_sync    <= {rx_sync[0], rxd};
            cts_sync   <= {cts_sync[0], cts_n};
            cts_prev   <= cts_sync[1];
            cts_change <= !cfg_hfc_en && !cfg_cts_dis && (cts_sync[1] != cts_prev);
        end
    end

    assign cts_block = cfg_hfc_en && !cfg_cts_dis && cts_sync[1];
    assign tx_ready  = !tx_busy && !cts_block;
    assign tx_go     = tx_valid && tx_ready;
    assign rts_n     = cfg_hfc_en && !rx_space;

    ufe_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .go(tx_go), .din(tx_data),
        .csize(cfg_char_size), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
        .par_zeros(cfg_par_zeros), .stop2(cfg_stop2), .txd(txd), .busy(tx_busy)
    );

    ufe_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rx_s(rx_sync[1]),
        .csize(cfg_char_size), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
        .par_zeros(cfg_par_zeros), .dpfe_en(cfg_dpfe_en), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_par_err(rx_par_err), .frame_err(frame_err),
        .par_err(par_err), .busy(rx_busy)
    );

    p_cts_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_busy) && cfg_hfc_en && !cfg_cts_dis) |-> $past(!cts_sync[1]));
    p_cts_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cts_change |-> $past(!cfg_hfc_en));

endmodule

// File: tb/sim_uart_frame_core.sv
module sim_uart_frame_core;
    localparam int OVS = 16;
    localparam int TDIV = 4;
    localparam int BITC = OVS * TDIV;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, baud_tick = 1'b0;
    logic [1:0] cfg_char_size = 2'd3;
    logic cfg_par_en = 0, cfg_par_odd = 0, cfg_par_zeros = 0, cfg_stop2 = 0;
    logic cfg_hfc_en = 0, cfg_cts_dis = 0, cfg_dpfe_en = 0;
    logic tx_valid = 0, rxd = 1'b1, cts_n = 1'b0, rx_space = 1'b1;
    logic [7:0] tx_data = '0;
    logic tx_ready, txd, rx_valid, rx_par_err, frame_err, par_err, rts_n, cts_change, tx_busy, rx_busy;
    logic [7:0] rx_data;

    uart_frame_core #(.OVS(OVS)) u0 (.*);

    int checks = 0, failures = 0, tdiv = 0, evt = 0;
    bit done = 0;
    logic [9:0]  rx_q[$];
    string       rx_tag_q[$];
    logic [11:0] tx_q[$];
    int          tx_len_q[$];

    always @(negedge clk) begin
        baud_tick <= (tdiv == TDIV - 1);
        tdiv <= (tdiv == TDIV - 1) ? 0 : tdiv + 1;
        if (cts_change) evt <= evt + 1;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    function automatic int nbits();
        return 5 + int'(cfg_char_size);
    endfunction

    // parity bit from the count rule of R2
    function automatic logic exp_par(input logic [7:0] d);
        int c = 0;
        for (int i = 0; i < nbits(); i++) if (d[i] != cfg_par_zeros) c++;
        if (!cfg_par_zeros) return logic'(c % 2) ^ cfg_par_odd;
        return ~(logic'(c % 2) ^ cfg_par_odd);
    endfunction

    // scoreboard monitor for received bytes
    logic [9:0] rexp;
    string      rtag;
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (rx_q.size() == 0) chk(0, "R4", "unexpected byte", rx_data, 0);
            else begin
                rexp = rx_q.pop_front();
                rtag = rx_tag_q.pop_front();
                chk(rx_data == rexp[7:0], rtag, "rx_data", rx_data, rexp[7:0]);
                chk(rx_par_err == rexp[8] && par_err == rexp[8], "R12", "parity error", {rx_par_err, par_err}, {rexp[8], rexp[8]});
                chk(frame_err == rexp[9], rtag, "frame_err", frame_err, rexp[9]);
            end
        end else if (rst_n && (frame_err || par_err)) begin
            chk(0, "R5", "error pulse without byte", {frame_err, par_err}, 0);
        end
    end

    // scoreboard monitor for the serial output
    logic [11:0] tgot, texp;
    int tlen;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                tlen = (tx_len_q.size() > 0) ? tx_len_q[0] : 12;
                tgot = '0;
                repeat (BITC / 2) @(negedge clk);
                tgot[0] = txd;
                for (int k = 1; k < tlen; k++) begin
                    repeat (BITC) @(negedge clk);
                    tgot[k] = txd;
                end
                if (tx_q.size() == 0) chk(0, "R1", "unexpected frame", tgot, 0);
                else begin
                    texp = tx_q.pop_front();
                    void'(tx_len_q.pop_front());
                    chk(tgot == texp, "R1", "txd frame bits", tgot, texp);
                end
                wait (txd === 1'b1);
            end
        end
    end

    task automatic tx_frame(input logic [7:0] d);
        logic [11:0] v = '0;
        int len = 1, busy_n = 0;
        for (int i = 0; i < nbits(); i++) v[len++] = d[i];
        if (cfg_par_en) v[len++] = exp_par(d);
        v[len++] = 1'b1;
        if (cfg_stop2) v[len++] = 1'b1;
        tx_q.push_back(v);
        tx_len_q.push_back(len);
        @(negedge clk);
        tx_valid = 1'b1;
        tx_data  = d;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        while (tx_busy) begin busy_n++; @(negedge clk); end
        chk(busy_n >= len * BITC - 4 && busy_n <= len * BITC, "R3", "tx_busy length", busy_n, len * BITC);
        repeat (BITC) @(negedge clk);
    endtask

    task automatic rx_frame(input logic [7:0] d, input bit bad_par, input bit stop_low,
                            input int flip, input string tag);
        logic p = exp_par(d) ^ bad_par;
        logic [7:0] m = d & (8'hFF >> (8 - nbits()));
        rx_q.push_back({stop_low || (cfg_dpfe_en && flip >= 0), cfg_par_en && bad_par, m});
        rx_tag_q.push_back(tag);
        @(negedge clk);
        rxd = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < nbits(); i++) begin
            rxd = d[i];
            if (i == 0) begin
                repeat (4) @(negedge clk);
                chk(rx_busy == 1'b1, "R11", "rx_busy during frame", rx_busy, 1);
                repeat (BITC - 4) @(negedge clk);
            end else if (i == flip) begin
                repeat (40) @(negedge clk);
                rxd = ~d[i];
                repeat (BITC - 40) @(negedge clk);
            end else repeat (BITC) @(negedge clk);
        end
        if (cfg_par_en) begin rxd = p; repeat (BITC) @(negedge clk); end
        rxd = !stop_low;
        repeat (BITC) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BITC) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] sz, input logic pe, input logic po,
                           input logic pz, input logic s2);
        @(negedge clk);
        cfg_char_size = sz; cfg_par_en = pe; cfg_par_odd = po; cfg_par_zeros = pz; cfg_stop2 = s2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd && !tx_busy && !rx_busy && !rx_valid && tx_ready, "R11", "reset state",
            {txd, tx_busy, rx_busy, rx_valid, tx_ready}, 5'b10001);
        repeat (10) @(negedge clk);

        // transmit patterns: R1 R2 R3
        set_cfg(2'd3, 0, 0, 0, 0); tx_frame(8'hA5);
        set_cfg(2'd0, 1, 0, 0, 0); tx_frame(8'h13);
        set_cfg(2'd2, 1, 1, 1, 1); tx_frame(8'h2C);
        set_cfg(2'd1, 1, 0, 1, 0); tx_frame(8'h15);
        set_cfg(2'd3, 1, 1, 0, 1); tx_frame(8'hF0);

        // receive patterns: R4 R12 R5
        set_cfg(2'd3, 0, 0, 0, 0); rx_frame(8'h3C, 0, 0, -1, "R4");
        set_cfg(2'd1, 1, 1, 0, 0); rx_frame(8'hE9, 0, 0, -1, "R4");
        set_cfg(2'd0, 1, 0, 1, 0); rx_frame(8'h0B, 1, 0, -1, "R12");
        set_cfg(2'd2, 0, 0, 0, 0); rx_frame(8'h55, 0, 1, -1, "R5");
        // both error pulses land with the same byte
        set_cfg(2'd3, 1, 0, 0, 0); rx_frame(8'hC3, 1, 1, -1, "R5");

        // start glitch: R6
        @(negedge clk); rxd = 1'b0;
        repeat (12) @(negedge clk); rxd = 1'b1;
        repeat (100) @(negedge clk);
        chk(!rx_busy && rx_q.size() == 0, "R6", "glitch dropped", rx_busy, 0);

        // bit stability check: R7
        cfg_dpfe_en = 1'b1; rx_frame(8'h96, 0, 0, 2, "R7");
        cfg_dpfe_en = 1'b0; rx_frame(8'h96, 0, 0, 2, "R7");

        // flow control gating: R8
        set_cfg(2'd3, 0, 0, 0, 0);
        cfg_hfc_en = 1'b1; cts_n = 1'b1;
        repeat (10) @(negedge clk);
        fork tx_frame(8'h5A); join_none
        repeat (300) @(negedge clk);
        chk(!tx_busy && txd, "R8", "held by cts", {tx_busy, txd}, 2'b01);
        cts_n = 1'b0;
        wait fork;
        cfg_cts_dis = 1'b1; cts_n = 1'b1;
        repeat (10) @(negedge clk);
        tx_frame(8'h81);
        chk(1'b1, "R8", "sent with cts ignored", 1, 1);
        cfg_cts_dis = 1'b0; cts_n = 1'b0; cfg_hfc_en = 1'b0;
        repeat (10) @(negedge clk);

        // change events: R9
        base = evt;
        cts_n = 1'b1; repeat (10) @(negedge clk);
        cts_n = 1'b0; repeat (10) @(negedge clk);
        chk(evt - base == 2, "R9", "events with flow control off", evt - base, 2);
        cfg_hfc_en = 1'b1; base = evt;
        cts_n = 1'b1; repeat (10) @(negedge clk);
        cts_n = 1'b0; repeat (10) @(negedge clk);
        chk(evt - base == 0, "R9", "events with flow control on", evt - base, 0);
        cfg_hfc_en = 1'b0; cfg_cts_dis = 1'b1; base = evt;
        cts_n = 1'b1; repeat (10) @(negedge clk);
        cts_n = 1'b0; repeat (10) @(negedge clk);
        chk(evt - base == 0, "R9", "events with cts ignored", evt - base, 0);
        cfg_cts_dis = 1'b0;

        // request-to-send: R10
        cfg_hfc_en = 1'b1; rx_space = 1'b0; #1;
        chk(rts_n == 1'b1, "R10", "rts with no space", rts_n, 1);
        @(negedge clk); rx_space = 1'b1; #1;
        chk(rts_n == 1'b0, "R10", "rts with space", rts_n, 0);
        @(negedge clk); cfg_hfc_en = 1'b0; rx_space = 1'b0; #1;
        chk(rts_n == 1'b0, "R10", "rts with flow control off", rts_n, 0);

        repeat (20) @(negedge clk);
        chk(rx_q.size() == 0 && tx_q.size() == 0, "R4", "scoreboard drained", rx_q.size() + tx_q.size(), 0);
        finish_run();
    end
endmodule